// File: doc/BRIEF.md
# Two-Wire Write-Only Control Register Slave

This block sits on a two-wire serial bus as a write-only slave and holds nine 8-bit control registers, numbered 0 to 8, whose contents are presented in parallel to the rest of the chip. The bus clock and data lines are brought into the system clock domain through two-stage synchronizers. The block then detects start and stop conditions, shifts in bytes on rising clock edges and acknowledges accepted bytes by driving the data line low through an open-drain pull output.

After the device address, the first byte of a transfer picks the access style from its two top bits. A quick write puts its low six bits straight into register 0 or register 1. A pointer write names the target register in its low four bits, and the data bytes that follow go there. In both styles, every further byte goes to the next register in turn until a stop arrives. One code of the two top bits is reserved and is refused. The top two bits of registers 0 and 1 are never written over the bus.

Top module: `ctl_regfile_slave`

## Requirements
- R1: After reset all nine registers read 0x00 and the pull output is inactive.
- R2: The only address byte acknowledged is 0x80 (7-bit address 1000000 followed by a write bit of 0). Any other address byte, including 0x81, is not acknowledged, and no register changes until the next start.
- R3: An accepted byte is acknowledged by asserting the pull output, which drives the data line low, from the falling clock edge after its eighth bit until the falling edge after the ninth clock. The pull output only becomes active while the clock is low, and it is inactive after a stop.
- R4: A first byte with bits 7:6 = 00 writes its bits 5:0 into register 0 bits 5:0. A first byte with bits 7:6 = 01 writes its bits 5:0 into register 1 bits 5:0. The byte is acknowledged.
- R5: A first byte with bits 7:6 = 10 is not acknowledged, and neither it nor any later byte of the transfer changes a register.
- R6: A first byte with bits 7:6 = 11 sets the register pointer to its bits 3:0 and is acknowledged. Bits 5:4 of that byte are ignored. The next data byte is written whole into the selected register.
- R7: After the first byte, each further data byte goes to the next register in increasing order and is acknowledged. This applies after both quick and pointer writes: after a quick write to register 0 the next byte goes to register 1, and after a quick write to register 1 it goes to register 2.
- R8: Bits 7:6 of registers 0 and 1 are never changed by any bus write. They keep their reset value of 0.
- R9: A pointer value above 8, either named in a first byte or reached by incrementing past register 8, causes that byte not to be acknowledged. No register changes for the rest of the transfer.
- R10: A start condition in the middle of a transfer abandons it and begins a new address phase. Bytes already written keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least ten times the bus bit rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High to drive the data line low (open-drain enable) |
| regs_o | output | 72 | Register contents, register n at bits 8n+7 to 8n |

## Verification
The bench plays every first-byte code against the same register file. Quick writes are told apart from pointer writes by which register and which bit field change. The reserved code and out-of-range pointers are told apart from valid ones by a missing acknowledge and by registers that stay unchanged. Multi-byte runs that cross from register 1 into 2, and from 8 into the refused ninth slot, show that the pointer increments and saturates as required. Wrong addresses, the read bit, a mid-transfer repeated start and seeded random transfers show that address matching gates every write and that bits 7:6 of registers 0 and 1 survive all traffic.

// File: rtl/ctl_regfile_slave.sv
module ctl_regfile_slave #(
  parameter logic [6:0] DEV_ADDR = 7'b1000000,
  parameter int NREG = 9,
  parameter int SYNC = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [8*NREG-1:0] regs_o
);

  localparam int PW = 4;
  localparam int QUICK_REGS = 2;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_FIRST, S_DATA, S_IGN} st_t;

  logic [SYNC-1:0] scl_sy, sda_sy;
  logic scl_s, sda_s, scl_q, sda_q;
  logic start_c, stop_c, scl_rise, scl_fall;
  st_t st, nxt_st;
  logic [3:0] bitcnt;
  logic in_ack;
  logic [7:0] sh;
  logic [PW-1:0] ptr, nxt_ptr, widx;
  logic byte_done, acc, wr;
  logic [7:0] regs [NREG];

  assign scl_s = scl_sy[SYNC-1];
  assign sda_s = sda_sy[SYNC-1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sy <= '1; sda_sy <= '1; scl_q <= 1'b1; sda_q <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[SYNC-2:0], scl_i};
      sda_sy <= {sda_sy[SYNC-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end

  assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;
  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;

  assign byte_done = scl_fall && !in_ack && bitcnt == 4'd8 &&
                     (st == S_ADDR || st == S_FIRST || st == S_DATA);

  always_comb begin
    acc = 1'b0; wr = 1'b0; nxt_st = st; nxt_ptr = ptr; widx = ptr;
    case (st)
      S_ADDR: begin
        if (sh == {DEV_ADDR, 1'b0}) begin acc = 1'b1; nxt_st = S_FIRST; end
        else nxt_st = S_IGN;
      end
      S_FIRST: begin
        case (sh[7:6])
          2'b00: begin wr = 1'b1; widx = 0; nxt_ptr = 1; acc = 1'b1; nxt_st = S_DATA; end
          2'b01: begin wr = 1'b1; widx = 1; nxt_ptr = 2; acc = 1'b1; nxt_st = S_DATA; end
          2'b10: nxt_st = S_IGN;
          default: begin
            if (int'(sh[3:0]) < NREG) begin
              nxt_ptr = sh[3:0]; acc = 1'b1; nxt_st = S_DATA;
            end else nxt_st = S_IGN;
          end
        endcase
      end
      S_DATA: begin
        if (int'(ptr) < NREG) begin
          wr = 1'b1; widx = ptr; nxt_ptr = ptr + 1'b1; acc = 1'b1;
        end else nxt_st = S_IGN;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; bitcnt <= '0; in_ack <= 1'b0; sh <= '0; ptr <= '0; sda_pull_o <= 1'b0;
    end else if (start_c) begin
      st <= S_ADDR; bitcnt <= '0; in_ack <= 1'b0; sda_pull_o <= 1'b0;
    end else if (stop_c) begin
      st <= S_IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_pull_o <= 1'b0;
    end else if (st == S_IDLE || st == S_IGN) begin
      sda_pull_o <= 1'b0;
    end else begin
      if (scl_rise && !in_ack && bitcnt < 4'd8) begin
        sh <= {sh[6:0], sda_s};
        bitcnt <= bitcnt + 1'b1;
      end
      if (scl_fall && in_ack) begin
        in_ack <= 1'b0; sda_pull_o <= 1'b0; bitcnt <= '0;
      end else if (byte_done) begin
        in_ack <= 1'b1; sda_pull_o <= acc; st <= nxt_st; ptr <= nxt_ptr;
      end
    end

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) regs[g] <= '0;
      else if (byte_done && wr && int'(widx) == g) begin
        if (g < QUICK_REGS) regs[g][5:0] <= sh[5:0];
        else regs[g] <= sh;
      end
    assign regs_o[8*g +: 8] = regs[g];
  end

  // R3
  ack_on_low_clk_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull_o) |-> !scl_s);

  // R3
  release_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_c |=> !sda_pull_o);

  // R2
  bad_addr_nack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_done && st == S_ADDR && sh != {DEV_ADDR, 1'b0}) |=> !sda_pull_o);

  // R8
  quick_hi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(regs_o[7:6]) && $stable(regs_o[15:14]));

  // R9
  ignore_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IGN) |=> $stable(regs_o));

endmodule

// File: tb/ctl_regfile_slave_tb.sv
module ctl_regfile_slave_tb_top;
  localparam int NREG = 9;
  localparam int Q = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  logic m_scl = 1'b1, m_sda = 1'b1;
  logic sda_pull_o;
  logic [8*NREG-1:0] regs_o;
  wire sda_line = m_sda & ~sda_pull_o;

  ctl_regfile_slave dut_i (.clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_line),
                           .sda_pull_o(sda_pull_o), .regs_o(regs_o));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] exp_r [NREG];
  logic [7:0] bb [16];
  int ms, mptr;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw(int n); repeat (n * Q) @(posedge clk); endtask

  task automatic bus_start();
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b0; qw(1); m_scl = 1'b0; qw(1);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; qw(1); m_scl = 1'b1; qw(1); m_sda = 1'b1; qw(2);
  endtask

  task automatic bus_byte(logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      m_sda = b[i]; qw(1); m_scl = 1'b1; qw(2); m_scl = 1'b0; qw(1);
    end
    m_sda = 1'b1; qw(1); m_scl = 1'b1; qw(1);
    @(negedge clk); ack = sda_pull_o;
    qw(1); m_scl = 1'b0; qw(1);
  endtask

  function automatic logic model_byte(logic [7:0] b);
    logic a = 1'b0;
    case (ms)
      0: if (b == 8'h80) begin a = 1; ms = 1; end else ms = 3;
      1: case (b[7:6])
           2'b00: begin exp_r[0][5:0] = b[5:0]; mptr = 1; a = 1; ms = 2; end
           2'b01: begin exp_r[1][5:0] = b[5:0]; mptr = 2; a = 1; ms = 2; end
           2'b10: ms = 3;
           default: if (b[3:0] < NREG) begin mptr = b[3:0]; a = 1; ms = 2; end else ms = 3;
         endcase
      2: if (mptr < NREG) begin
           if (mptr < 2) exp_r[mptr][5:0] = b[5:0]; else exp_r[mptr] = b;
           mptr++; a = 1;
         end else ms = 3;
      default: ;
    endcase
    return a;
  endfunction

  task automatic run(string tag, int n, bit stp);
    logic ack;
    bus_start();
    ms = 0;
    for (int i = 0; i < n; i++) begin
      logic e;
      e = model_byte(bb[i]);
      bus_byte(bb[i], ack);
      chk($sformatf("%s ack byte %0d", tag, i), ack, e);
    end
    if (stp) begin
      bus_stop();
      chk({tag, " released"}, sda_pull_o, 0);
      for (int r = 0; r < NREG; r++)
        chk($sformatf("%s reg %0d", tag, r), regs_o[8*r +: 8], exp_r[r]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    for (int r = 0; r < NREG; r++) exp_r[r] = 8'h00;
    repeat (5) @(posedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 pull", sda_pull_o, 0);
    chk("R1 regs", regs_o, '0);

    // R4 quick write R0, R7 then R1 and R2, R8 hi bits kept
    bb[0] = 8'h80; bb[1] = 8'h2B; bb[2] = 8'hFF; bb[3] = 8'hC3;
    run("R4_R7_R8 quick0", 4, 1);
    // R4 quick write R1 then R2
    bb[0] = 8'h80; bb[1] = 8'h55; bb[2] = 8'h9A;
    run("R4_R7 quick1", 3, 1);
    // R5 reserved code
    bb[0] = 8'h80; bb[1] = 8'hBF; bb[2] = 8'h77; bb[3] = 8'h66;
    run("R5 reserved", 4, 1);
    // R6 pointer write with bits 5:4 set, R7 increment to R8, R9 past end
    bb[0] = 8'h80; bb[1] = 8'hF6; bb[2] = 8'hA1; bb[3] = 8'hB2; bb[4] = 8'hC3; bb[5] = 8'hD4;
    run("R6_R7_R9 ptr6", 6, 1);
    // R8 pointer write to R0 with bits 7:6 set
    bb[0] = 8'h80; bb[1] = 8'hC0; bb[2] = 8'hC5; bb[3] = 8'hFA;
    run("R8 ptr0", 4, 1);
    // R9 pointer above 8
    bb[0] = 8'h80; bb[1] = 8'hCC; bb[2] = 8'h12;
    run("R9 ptr12", 3, 1);
    bb[0] = 8'h80; bb[1] = 8'hC9; bb[2] = 8'h34;
    run("R9 ptr9", 3, 1);
    // R2 wrong address and read bit
    bb[0] = 8'h82; bb[1] = 8'h01; bb[2] = 8'h02;
    run("R2 wrong", 3, 1);
    bb[0] = 8'h81; bb[1] = 8'h03;
    run("R2 read", 2, 1);
    // R10 repeated start mid transfer
    bb[0] = 8'h80; bb[1] = 8'hC3; bb[2] = 8'h11;
    run("R10 first", 3, 0);
    bb[0] = 8'h80; bb[1] = 8'h2A; bb[2] = 8'h5C;
    run("R10 second", 3, 1);

    // random traffic, R3 acks checked per byte
    for (int t = 0; t < 40; t++) begin
      int n;
      n = 2 + int'($urandom_range(0, 4));
      bb[0] = ($urandom_range(0, 7) == 0) ? 8'(($urandom_range(0, 255)) | 1) : 8'h80;
      bb[1] = 8'($urandom_range(0, 255));
      if (bb[1][7:6] == 2'b11) bb[1][3:0] = 4'($urandom_range(0, 10));
      for (int i = 2; i < n; i++) bb[i] = 8'($urandom_range(0, 255));
      run("R3_R7 random", n, 1);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule